// File: doc/BRIEF.md
# Interprocessor Interrupt Command Unit

This block gives local software a 64-bit command register for sending an interrupt message to other processors. It is split into a low word and a high word. The high word holds an 8-bit destination. The low word holds these fields:

- vector
- delivery mode
- destination mode
- level
- trigger mode
- destination shorthand

A write to the low word launches the message on a request/acknowledge port. The message carries a per-processor target bitmask and the command fields.

The shorthand selects how the target mask is built:

- from the destination field, in physical or flat logical form
- the local processor only
- every processor
- every processor except the local one

Software polls a read-only pending bit in the low word until the acknowledge returns. Then it issues the next command. A low-word write that arrives while a message is pending is dropped. So is a command with a reserved delivery mode. Either case raises a sticky error flag.

The usual start-up sequence uses two commands:

- low word `0x000C4500`: INIT to all processors except self, level asserted
- low word `0x000C4611`: start-up to all processors except self with vector 0x11, which names entry page 0x11 (entry address = vector << 12)

Top module: `ipi_cmd_unit`

## Requirements
- R1: After synchronous reset, `msg_req` and `err_flag` are 0 and both words read back as 0.
- R2: Register layout. The low word stores vector [7:0], delivery mode [10:8], destination mode [11] (0 physical, 1 logical), level [14], trigger [15] and shorthand [19:18]. The low word reads pending status at bit 12. The high word stores the destination in [31:24]. All other bits read 0, and a read returns data one cycle after `bus_re`.
- R3: An idle low-word write with a non-reserved mode raises `msg_req` in the next cycle. The message presents the written vector, mode, destination mode, level and trigger. The status bit reads 1 while `msg_req` is high.
- R4: With shorthand 00, a physical destination d sets only target bit d, and no bit if d >= N. A logical destination sets target bit i for each destination bit i.
- R5: Shorthand 01 sets only the local-ID bit, 10 sets all N bits, and 11 sets all bits except the local-ID bit.
- R6: `msg_req` and all message fields hold steady until `msg_ack`. On the edge where `msg_req` and `msg_ack` are both high, the request and the status bit clear.
- R7: A low-word write while pending does not change the stored low word or the message, and it sets `err_flag`.
- R8: Delivery modes 011 and 111 are reserved. Such a command is stored but not sent, status stays 0, and `err_flag` is set.
- R9: `err_flag` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| local_id | input | 8 | Identifier of the local processor |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr_hi | input | 1 | Word select: 1 high word, 0 low word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| msg_req | output | 1 | Message request, held until acknowledged |
| msg_ack | input | 1 | Message acknowledge |
| msg_targets | output | NPROC | Target processor bitmask |
| msg_vector | output | 8 | Interrupt vector |
| msg_mode | output | 3 | Delivery mode |
| msg_logical | output | 1 | Destination mode |
| msg_level | output | 1 | Level (assert/de-assert) |
| msg_trigger | output | 1 | Trigger mode (edge/level) |
| err_flag | output | 1 | Sticky error flag |

## Verification
Some behaviours are checked by the assertions on every cycle:

- a request stays held and stable until it is acknowledged
- the request drops at the acknowledge edge
- a busy write raises the error and leaves the message unchanged
- a reserved mode never reaches the port
- the error stays set
- the self-only shorthand never yields more than one target

Other behaviours can only be shown by the bench's scenarios:

- the exact target mask for each shorthand and destination form
- the bit positions seen on readback
- the start-up command encodings
- the reset state

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_LOWPRI = 3'b001,
    DM_SMI    = 3'b010,
    DM_RSV3   = 3'b011,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_START  = 3'b110,
    DM_RSV7   = 3'b111
  } dmode_e;

  typedef enum logic [1:0] {
    SH_NONE   = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } short_e;

  typedef struct packed {
    logic       trigger;
    logic       level;
    short_e     sh;
    logic       logical;
    dmode_e     mode;
    logic [7:0] vector;
  } cmd_t;

  localparam int STATUS_BIT = 12;

  function automatic cmd_t unpack_lo(input logic [31:0] w);
    cmd_t c;
    c.vector  = w[7:0];
    c.mode    = dmode_e'(w[10:8]);
    c.logical = w[11];
    c.level   = w[14];
    c.trigger = w[15];
    c.sh      = short_e'(w[19:18]);
    return c;
  endfunction

  function automatic logic [31:0] pack_lo(input cmd_t c, input logic pend);
    logic [31:0] w;
    w          = '0;
    w[7:0]     = c.vector;
    w[10:8]    = c.mode;
    w[11]      = c.logical;
    w[STATUS_BIT] = pend;
    w[14]      = c.level;
    w[15]      = c.trigger;
    w[19:18]   = c.sh;
    return w;
  endfunction

  function automatic logic is_reserved(input dmode_e m);
    return (m == DM_RSV3) || (m == DM_RSV7);
  endfunction

endpackage

// File: rtl/ipi_regs.sv
module ipi_regs
  import ipi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic              addr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic              accept_lo,
  input  logic              pending,
  output cmd_t              cmd_q,
  output logic [DEST_W-1:0] dest_q,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEST_LSB = DATA_W - DEST_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      dest_q <= '0;
      rdata  <= '0;
    end else begin
      if (accept_lo)
        cmd_q <= unpack_lo(wdata);
      if (we && addr_hi)
        dest_q <= wdata[DATA_W-1:DEST_LSB];
      if (re) begin
        if (addr_hi)
          rdata <= {dest_q, {DEST_LSB{1'b0}}};
        else
          rdata <= pack_lo(cmd_q, pending);
      end
    end
  end

  AST_DEST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(we && addr_hi) |=> $stable(dest_q)); // R2

  AST_LO_HOLD: assert property (@(posedge clk) disable iff (rst)
    !accept_lo |=> $stable(cmd_q)); // R7

endmodule

// File: rtl/ipi_dest_decode.sv
module ipi_dest_decode
  import ipi_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int DEST_W = 8
) (
  input  short_e            sh,
  input  logic              logical,
  input  logic [DEST_W-1:0] dest,
  input  logic [DEST_W-1:0] self_id,
  output logic [NPROC-1:0]  mask
);

  logic [NPROC-1:0] self_oh;
  logic [NPROC-1:0] field_mask;

  for (genvar i = 0; i < NPROC; i++) begin : g_bit
    assign self_oh[i] = (self_id == DEST_W'(i));
    if (i < DEST_W) begin : g_log
      assign field_mask[i] = logical ? dest[i] : (dest == DEST_W'(i));
    end else begin : g_phys
      assign field_mask[i] = !logical && (dest == DEST_W'(i));
    end
  end

  always_comb begin
    unique case (sh)
      SH_NONE:   mask = field_mask;
      SH_SELF:   mask = self_oh;
      SH_ALL:    mask = '1;
      SH_OTHERS: mask = ~self_oh;
      default:   mask = '0;
    endcase
  end

endmodule

// File: rtl/ipi_launch.sv
module ipi_launch
  import ipi_pkg::*;
#(
  parameter int NPROC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_lo,
  input  cmd_t             cmd_in,
  input  logic [NPROC-1:0] mask_in,
  input  logic             ack,
  output logic             accept,
  output logic             req,
  output logic             err,
  output cmd_t             msg_cmd,
  output logic [NPROC-1:0] msg_mask
);

  logic rsv;
  assign rsv    = is_reserved(cmd_in.mode);
  assign accept = wr_lo && !req;

  always_ff @(posedge clk) begin
    if (rst) begin
      req      <= 1'b0;
      err      <= 1'b0;
      msg_cmd  <= '0;
      msg_mask <= '0;
    end else begin
      if (accept && !rsv) begin
        req      <= 1'b1;
        msg_cmd  <= cmd_in;
        msg_mask <= mask_in;
      end else if (req && ack) begin
        req <= 1'b0;
      end
      if ((wr_lo && req) || (accept && rsv))
        err <= 1'b1;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req && !ack |=> req && $stable(msg_mask) && $stable(msg_cmd)); // R6

  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    req && ack |=> !req); // R6

  AST_BUSY_ERR: assert property (@(posedge clk) disable iff (rst)
    wr_lo && req |=> err && $stable(msg_cmd)); // R7

  AST_NO_RSV_SENT: assert property (@(posedge clk) disable iff (rst)
    req |-> !is_reserved(msg_cmd.mode)); // R8

  AST_RSV_NO_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    wr_lo && !req && rsv |=> !req && err); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R9

endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
  import ipi_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int DATA_W = 32,
  parameter int DEST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DEST_W-1:0] local_id,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              bus_addr_hi,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              msg_req,
  input  logic              msg_ack,
  output logic [NPROC-1:0]  msg_targets,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_mode,
  output logic              msg_logical,
  output logic              msg_level,
  output logic              msg_trigger,
  output logic              err_flag
);

  logic              wr_lo;
  logic              accept;
  cmd_t              cmd_new;
  cmd_t              cmd_q;
  cmd_t              msg_cmd;
  logic [DEST_W-1:0] dest_q;
  logic [NPROC-1:0]  mask_new;

  assign wr_lo   = bus_we && !bus_addr_hi;
  assign cmd_new = unpack_lo(bus_wdata);

  ipi_regs #(.DATA_W(DATA_W), .DEST_W(DEST_W)) i_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (bus_we),
    .re        (bus_re),
    .addr_hi   (bus_addr_hi),
    .wdata     (bus_wdata),
    .accept_lo (accept),
    .pending   (msg_req),
    .cmd_q     (cmd_q),
    .dest_q    (dest_q),
    .rdata     (bus_rdata)
  );

  ipi_dest_decode #(.NPROC(NPROC), .DEST_W(DEST_W)) i_decode (
    .sh      (cmd_new.sh),
    .logical (cmd_new.logical),
    .dest    (dest_q),
    .self_id (local_id),
    .mask    (mask_new)
  );

  ipi_launch #(.NPROC(NPROC)) i_launch (
    .clk      (clk),
    .rst      (rst),
    .wr_lo    (wr_lo),
    .cmd_in   (cmd_new),
    .mask_in  (mask_new),
    .ack      (msg_ack),
    .accept   (accept),
    .req      (msg_req),
    .err      (err_flag),
    .msg_cmd  (msg_cmd),
    .msg_mask (msg_targets)
  );

  assign msg_vector  = msg_cmd.vector;
  assign msg_mode    = msg_cmd.mode;
  assign msg_logical = msg_cmd.logical;
  assign msg_level   = msg_cmd.level;
  assign msg_trigger = msg_cmd.trigger;

  AST_SELF_ONLY: assert property (@(posedge clk) disable iff (rst)
    msg_req && (msg_cmd.sh == SH_SELF) |-> $onehot0(msg_targets)); // R5

  AST_ALL_FULL: assert property (@(posedge clk) disable iff (rst)
    msg_req && (msg_cmd.sh == SH_ALL) |-> (msg_targets == '1)); // R5

endmodule

// File: tb/test_ipi_cmd_unit.sv
module test_ipi_cmd_unit;

  localparam int N = 4;
  localparam logic [31:0] LO_MASK = 32'h000C_CFFF;

  typedef struct packed {
    logic [31:0]  lo;
    logic [7:0]   dest;
    logic [7:0]   id;
    logic [N-1:0] mask;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{32'h000C_4500, 8'h00, 8'h00, 4'b1110},
    '{32'h000C_4611, 8'h00, 8'h02, 4'b1011},
    '{32'h0000_4030, 8'h02, 8'h01, 4'b0100},
    '{32'h0000_0841, 8'h0A, 8'h00, 4'b1010},
    '{32'h0004_0120, 8'h00, 8'h03, 4'b1000},
    '{32'h0008_8422, 8'h00, 8'h01, 4'b1111},
    '{32'h0000_0005, 8'h09, 8'h00, 4'b0000}
  };

  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  local_id = '0;
  logic        bus_we = 0, bus_re = 0, bus_addr_hi = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        msg_req, msg_ack = 0;
  logic [N-1:0] msg_targets;
  logic [7:0]  msg_vector;
  logic [2:0]  msg_mode;
  logic        msg_logical, msg_level, msg_trigger, err_flag;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [31:0] rd;

  always #10 clk = ~clk;

  ipi_cmd_unit #(.NPROC(N)) i_ipi_cmd_unit (
    .clk(clk), .rst(rst), .local_id(local_id),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr_hi(bus_addr_hi),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .msg_req(msg_req), .msg_ack(msg_ack), .msg_targets(msg_targets),
    .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_logical(msg_logical),
    .msg_level(msg_level), .msg_trigger(msg_trigger), .err_flag(err_flag)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit hi, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr_hi = hi; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rdw(input bit hi, output logic [31:0] d);
    @(negedge clk);
    bus_re = 1; bus_addr_hi = hi;
    @(negedge clk);
    bus_re = 0;
    d = bus_rdata;
  endtask

  task automatic do_ack();
    @(negedge clk);
    msg_ack = 1;
    @(negedge clk);
    msg_ack = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    check(msg_req == 0, "R1 req after reset", {31'd0, msg_req}, 0);
    check(err_flag == 0, "R1 err after reset", {31'd0, err_flag}, 0);
    rdw(0, rd); check(rd == 0, "R1 low word after reset", rd, 0);
    rdw(1, rd); check(rd == 0, "R1 high word after reset", rd, 0);

    // R2 high word layout: only [31:24] kept
    wr(1, 32'hABFF_FFFF);
    rdw(1, rd); check(rd == 32'hAB00_0000, "R2 high word readback", rd, 32'hAB00_0000);

    // table walk: R3 R4 R5 R6
    for (int k = 0; k < NV; k++) begin
      local_id = VEC[k].id;
      wr(1, {VEC[k].dest, 24'h0});
      wr(0, VEC[k].lo);
      check(msg_req == 1, "R3 request raised", {31'd0, msg_req}, 1);
      check(msg_targets == VEC[k].mask, (VEC[k].lo[19:18] == 2'b00) ? "R4 target mask" : "R5 target mask",
            {28'd0, msg_targets}, {28'd0, VEC[k].mask});
      check({msg_trigger, msg_level, msg_logical, msg_mode, msg_vector} ==
            {VEC[k].lo[15], VEC[k].lo[14], VEC[k].lo[11], VEC[k].lo[10:0]}, "R3 message fields",
            {18'd0, msg_trigger, msg_level, msg_logical, msg_mode, msg_vector},
            {18'd0, VEC[k].lo[15], VEC[k].lo[14], VEC[k].lo[11], VEC[k].lo[10:0]});
      rdw(0, rd);
      check(rd == ((VEC[k].lo & LO_MASK) | 32'h1000), "R2 low readback with status", rd,
            (VEC[k].lo & LO_MASK) | 32'h1000);
      repeat (3) @(negedge clk);
      check(msg_req == 1 && msg_vector == VEC[k].lo[7:0], "R6 held without ack",
            {23'd0, msg_req, msg_vector}, {23'd0, 1'b1, VEC[k].lo[7:0]});
      do_ack();
      check(msg_req == 0, "R6 request cleared by ack", {31'd0, msg_req}, 0);
      rdw(0, rd);
      check(rd[12] == 0, "R6 status cleared", rd, VEC[k].lo & LO_MASK);
      check(err_flag == 0, "R3 no error on valid command", {31'd0, err_flag}, 0);
    end

    // R7 busy write ignored
    local_id = 0;
    wr(0, 32'h0008_0033);
    wr(0, 32'h000C_4577);
    check(err_flag == 1, "R7 error on busy write", {31'd0, err_flag}, 1);
    check(msg_vector == 8'h33 && msg_targets == 4'b1111, "R7 message unchanged",
          {20'd0, msg_targets, msg_vector}, {20'd0, 4'b1111, 8'h33});
    rdw(0, rd);
    check(rd == 32'h0008_1033, "R7 stored word unchanged", rd, 32'h0008_1033);
    do_ack();
    check(msg_req == 0, "R7 no second message", {31'd0, msg_req}, 0);

    // R8 reserved mode
    do_reset();
    wr(0, 32'h0008_0344);
    check(msg_req == 0, "R8 reserved mode not sent", {31'd0, msg_req}, 0);
    check(err_flag == 1, "R8 error on reserved mode", {31'd0, err_flag}, 1);
    rdw(0, rd);
    check(rd == 32'h0008_0344, "R8 stored, status idle", rd, 32'h0008_0344);
    wr(0, 32'h0000_0799);
    check(msg_req == 0, "R8 mode 111 not sent", {31'd0, msg_req}, 0);

    // R9 sticky across a valid command
    wr(0, 32'h0008_0010);
    check(msg_req == 1, "R9 valid command after error", {31'd0, msg_req}, 1);
    do_ack();
    repeat (3) @(negedge clk);
    check(err_flag == 1, "R9 error stays set", {31'd0, err_flag}, 1);
    do_reset();
    check(err_flag == 0, "R9 error cleared by reset", {31'd0, err_flag}, 0);

    finish_run();
  end

endmodule